// File: doc/BRIEF.md
# Level-Sensitive 64-Line Interrupt Aggregator

The block gathers a parameterised set of peripheral request lines (64 by default) into one interrupt toward a processor. Each line has a pending flag that is set while the line is high at a clock edge. The flag stays set until software clears it. A per-line enable bit qualifies each flag. The qualified flags are visible as status words, and any qualified flag, together with a routing setting, raises the processor interrupt.

Software reaches the block through a plain strobe port. There is one request strobe, a write flag, a word address that carries byte-address bits 11:2, four byte-lane enables and 32-bit write data. Read data is registered. Lanes are little-endian, so lane k of the word at byte address A holds byte A+k. A byte-wide read-modify-write of one enable byte is therefore a word access with a single lane enabled.

Because the lines are level-type, a line that is still high when its flag is cleared sets the flag again at once. Software therefore quiets the peripheral first and clears the flag after it.

Top module: `irq_hub`

## Requirements
- R1: After reset, all enable bits, pending flags and the routing byte are 0, `irq_o` is low, and every readable word returns 0.
- R2: A source that is high at a rising edge sets its pending flag at that edge. The flag stays set after the source falls and until a clear, whether or not the source is enabled.
- R3: Enable bits for sources 0–31 live in the word at byte 0x50, and those for sources 32–63 live in the word at byte 0x54 (bit i of the word at 0x50 is source i, bit i of the word at 0x54 is source 32+i). A write changes only the lanes whose byte enable is 1. Reads return the stored bits.
- R4: Reading byte 0x58 returns the pending flags of sources 0–31 ANDed with their enables. Reading byte 0x5C does the same for sources 32–63.
- R5: Flags are cleared through byte 0x40 + n (words 0x40 and 0x44 with lanes). A 1 in bit k of byte n clears the flag of source 8n+k. Zero bits and disabled lanes leave flags unchanged.
- R6: If a source is high in the same cycle as a clear for its flag, the flag remains set (set wins), so a level source that is still asserted re-pends.
- R7: Reads of the flag-clear words return 0.
- R8: The routing byte is at byte 0x3A4 (lane 0, readable). Bit 0 selects output channel 1 and bit 1 selects the fast class. `irq_o` is high exactly when some enabled flag is pending, bit 0 is 1 and bit 1 is 0.
- R9: Read data appears on `rdata_o` in the cycle after the read strobe. Unmapped addresses read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 64 | Level interrupt request lines |
| req_i | input | 1 | Access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| waddr_i | input | 10 | Word address (byte address bits 11:2) |
| be_i | input | 4 | Byte-lane enables for writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt toward the processor |

## Verification
The assertions assume that the source lines and bus inputs change only between rising edges and are stable at each edge. They also assume reset is held across at least one edge before operation starts. The bench drives every input on the falling edge and releases reset only after several cycles. Random phases mix sparse source patterns with accesses to every mapped word, to one unmapped word and to random lane enables. The set-versus-clear collision is exercised both in directed cases and by chance.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

   localparam int DATA_W = 32;
   localparam int LANE_W = 8;
   localparam int LANES  = DATA_W / LANE_W;

   typedef enum logic [2:0] {
      RG_NONE,
      RG_CLR,
      RG_EN,
      RG_STAT,
      RG_ROUTE
   } region_e;

   function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] be);
      logic [DATA_W-1:0] m;
      for (int l = 0; l < LANES; l++) begin
         m[l*LANE_W +: LANE_W] = {LANE_W{be[l]}};
      end
      return m;
   endfunction

endpackage

// File: rtl/irq_hub_decode.sv
module irq_hub_decode
   import irq_hub_pkg::*;
#(
   parameter int                ADDR_W     = 12,
   parameter int                N_WORDS    = 2,
   parameter int                IDX_W      = 1,
   parameter logic [ADDR_W-1:0] CLR_BASE   = 12'h040,
   parameter logic [ADDR_W-1:0] EN_BASE    = 12'h050,
   parameter logic [ADDR_W-1:0] STAT_BASE  = 12'h058,
   parameter logic [ADDR_W-1:0] ROUTE_ADDR = 12'h3A4
) (
   input  logic [ADDR_W-3:0] waddr_i,
   output region_e           region_o,
   output logic [IDX_W-1:0]  idx_o
);

   localparam int WA_W = ADDR_W - 2;
   localparam logic [WA_W-1:0] CLR_W   = CLR_BASE[ADDR_W-1:2];
   localparam logic [WA_W-1:0] EN_W    = EN_BASE[ADDR_W-1:2];
   localparam logic [WA_W-1:0] STAT_W  = STAT_BASE[ADDR_W-1:2];
   localparam logic [WA_W-1:0] ROUTE_W = ROUTE_ADDR[ADDR_W-1:2];

   always_comb begin
      region_o = RG_NONE;
      idx_o    = '0;
      for (int w = 0; w < N_WORDS; w++) begin
         if (waddr_i == CLR_W + WA_W'(w)) begin
            region_o = RG_CLR;
            idx_o    = IDX_W'(w);
         end
         if (waddr_i == EN_W + WA_W'(w)) begin
            region_o = RG_EN;
            idx_o    = IDX_W'(w);
         end
         if (waddr_i == STAT_W + WA_W'(w)) begin
            region_o = RG_STAT;
            idx_o    = IDX_W'(w);
         end
      end
      if (waddr_i == ROUTE_W) begin
         region_o = RG_ROUTE;
         idx_o    = '0;
      end
   end

endmodule

// File: rtl/irq_hub_enables.sv
module irq_hub_enables
   import irq_hub_pkg::*;
#(
   parameter int N_WORDS = 2,
   parameter int IDX_W   = 1
) (
   input  logic                           clk_i,
   input  logic                           rst_ni,
   input  logic                           wr_i,
   input  logic [IDX_W-1:0]               idx_i,
   input  logic [LANES-1:0]               be_i,
   input  logic [DATA_W-1:0]              wdata_i,
   output logic [N_WORDS-1:0][DATA_W-1:0] en_o
);

   for (genvar w = 0; w < N_WORDS; w++) begin : g_word
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               en_o[w][l*LANE_W +: LANE_W] <= '0;
            end else if (wr_i && idx_i == IDX_W'(w) && be_i[l]) begin
               en_o[w][l*LANE_W +: LANE_W] <= wdata_i[l*LANE_W +: LANE_W];
            end
         end
      end
   end

   AST_EN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_i |=> $stable(en_o)); // R3

   AST_EN_LANE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && be_i == '0) |=> $stable(en_o)); // R3

endmodule

// File: rtl/irq_hub_flags.sv
module irq_hub_flags #(
   parameter int N_SRC = 64
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N_SRC-1:0] src_i,
   input  logic [N_SRC-1:0] clr_i,
   output logic [N_SRC-1:0] flag_o
);

   for (genvar s = 0; s < N_SRC; s++) begin : g_src
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            flag_o[s] <= 1'b0;
         end else if (src_i[s]) begin
            flag_o[s] <= 1'b1;
         end else if (clr_i[s]) begin
            flag_o[s] <= 1'b0;
         end
      end
   end

   AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src_i != '0) |=> ((flag_o & $past(src_i)) == $past(src_i))); // R6

   AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((flag_o & ~clr_i) != '0) |=>
      ((flag_o & $past(flag_o & ~clr_i)) == $past(flag_o & ~clr_i))); // R2

   AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src_i == '0) |=> ((flag_o & ~$past(flag_o)) == '0)); // R2

   AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((clr_i & ~src_i) != '0) |=> ((flag_o & $past(clr_i & ~src_i)) == '0)); // R5

endmodule

// File: rtl/irq_hub.sv
module irq_hub
   import irq_hub_pkg::*;
#(
   parameter int                N_SRC          = 64,
   parameter int                ADDR_W         = 12,
   parameter logic [ADDR_W-1:0] CLR_BASE       = 12'h040,
   parameter logic [ADDR_W-1:0] EN_BASE        = 12'h050,
   parameter logic [ADDR_W-1:0] STAT_BASE      = 12'h058,
   parameter logic [ADDR_W-1:0] ROUTE_ADDR     = 12'h3A4,
   parameter int                ROUTE_W        = 8,
   parameter int                ROUTE_CH_BIT   = 0,
   parameter int                ROUTE_FAST_BIT = 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [N_SRC-1:0]  src_i,
   input  logic              req_i,
   input  logic              we_i,
   input  logic [ADDR_W-3:0] waddr_i,
   input  logic [3:0]        be_i,
   input  logic [31:0]       wdata_i,
   output logic [31:0]       rdata_o,
   output logic              irq_o
);

   localparam int N_WORDS = N_SRC / DATA_W;
   localparam int IDX_W   = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;

   if (N_SRC % DATA_W != 0 || N_SRC < DATA_W) begin : g_bad_nsrc
      $error("irq_hub: N_SRC must be a positive multiple of 32");
   end
   if (ROUTE_W < 2 || ROUTE_W > LANE_W) begin : g_bad_route_w
      $error("irq_hub: ROUTE_W must lie between 2 and 8");
   end
   if (ROUTE_CH_BIT >= ROUTE_W || ROUTE_FAST_BIT >= ROUTE_W ||
       ROUTE_CH_BIT == ROUTE_FAST_BIT) begin : g_bad_route_bits
      $error("irq_hub: routing bit positions invalid");
   end
   if (CLR_BASE[1:0] != 2'b00 || EN_BASE[1:0] != 2'b00 ||
       STAT_BASE[1:0] != 2'b00 || ROUTE_ADDR[1:0] != 2'b00) begin : g_bad_align
      $error("irq_hub: register bases must be word aligned");
   end

   region_e                        region;
   logic [IDX_W-1:0]               idx;
   logic                           wr_acc;
   logic                           rd_acc;
   logic [N_WORDS-1:0][DATA_W-1:0] en_w;
   logic [N_WORDS-1:0][DATA_W-1:0] stat_w;
   logic [N_WORDS-1:0][DATA_W-1:0] clr_w;
   logic [N_SRC-1:0]               flags;
   logic [N_SRC-1:0]               clr_vec;
   logic [N_SRC-1:0]               en_vec;
   logic [DATA_W-1:0]              wmask;
   logic [ROUTE_W-1:0]             route_q;
   logic [DATA_W-1:0]              rd_next;

   assign wr_acc = req_i && we_i;
   assign rd_acc = req_i && !we_i;
   assign wmask  = lane_mask(be_i);

   irq_hub_decode #(
      .ADDR_W     (ADDR_W),
      .N_WORDS    (N_WORDS),
      .IDX_W      (IDX_W),
      .CLR_BASE   (CLR_BASE),
      .EN_BASE    (EN_BASE),
      .STAT_BASE  (STAT_BASE),
      .ROUTE_ADDR (ROUTE_ADDR)
   ) i_decode (
      .waddr_i  (waddr_i),
      .region_o (region),
      .idx_o    (idx)
   );

   irq_hub_enables #(
      .N_WORDS (N_WORDS),
      .IDX_W   (IDX_W)
   ) i_enables (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (wr_acc && region == RG_EN),
      .idx_i   (idx),
      .be_i    (be_i),
      .wdata_i (wdata_i),
      .en_o    (en_w)
   );

   for (genvar w = 0; w < N_WORDS; w++) begin : g_clr
      assign clr_w[w] = (wr_acc && region == RG_CLR && idx == IDX_W'(w)) ?
                        (wdata_i & wmask) : '0;
   end

   assign clr_vec = clr_w;
   assign en_vec  = en_w;

   irq_hub_flags #(
      .N_SRC (N_SRC)
   ) i_flags (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .src_i  (src_i),
      .clr_i  (clr_vec),
      .flag_o (flags)
   );

   assign stat_w = flags & en_vec;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         route_q <= '0;
      end else if (wr_acc && region == RG_ROUTE && be_i[0]) begin
         route_q <= wdata_i[ROUTE_W-1:0];
      end
   end

   always_comb begin
      unique case (region)
         RG_EN:    rd_next = en_w[idx];
         RG_STAT:  rd_next = stat_w[idx];
         RG_ROUTE: rd_next = {{(DATA_W-ROUTE_W){1'b0}}, route_q};
         default:  rd_next = '0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rdata_o <= '0;
      end else if (rd_acc) begin
         rdata_o <= rd_next;
      end
   end

   assign irq_o = (|stat_w) && route_q[ROUTE_CH_BIT] && !route_q[ROUTE_FAST_BIT];

   AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((flags & en_vec) == '0) |-> !irq_o); // R8

   AST_CLR_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_acc && region == RG_CLR) |=> (rdata_o == '0)); // R7

   AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_acc && region == RG_NONE) |=> (rdata_o == '0)); // R9

   AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_acc |=> $stable(rdata_o)); // R9

endmodule

// File: tb/test_irq_hub.sv
module test_irq_hub;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] src = '0;
   logic        req = 1'b0;
   logic        we = 1'b0;
   logic [9:0]  waddr = '0;
   logic [3:0]  be = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int total = 0;
   int bad = 0;

   logic [63:0] m_en = '0;
   logic [63:0] m_fl = '0;
   logic [7:0]  m_rt = '0;

   localparam logic [9:0] A_CLR0 = 10'h010;
   localparam logic [9:0] A_CLR1 = 10'h011;
   localparam logic [9:0] A_EN0  = 10'h014;
   localparam logic [9:0] A_EN1  = 10'h015;
   localparam logic [9:0] A_ST0  = 10'h016;
   localparam logic [9:0] A_ST1  = 10'h017;
   localparam logic [9:0] A_RT   = 10'h0E9;
   localparam logic [9:0] A_NONE = 10'h020;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_hub i_irq_hub (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .src_i   (src),
      .req_i   (req),
      .we_i    (we),
      .waddr_i (waddr),
      .be_i    (be),
      .wdata_i (wdata),
      .rdata_o (rdata),
      .irq_o   (irq)
   );

   function automatic logic [31:0] lm(input logic [3:0] b);
      logic [31:0] m;
      for (int l = 0; l < 4; l++) m[l*8 +: 8] = {8{b[l]}};
      return m;
   endfunction

   function automatic logic [31:0] exp_rd(input logic [9:0] a);
      case (a)
         A_EN0:   return m_en[31:0];
         A_EN1:   return m_en[63:32];
         A_ST0:   return m_fl[31:0] & m_en[31:0];
         A_ST1:   return m_fl[63:32] & m_en[63:32];
         A_RT:    return {24'h0, m_rt};
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic exp_irq();
      return (|(m_fl & m_en)) && m_rt[0] && !m_rt[1];
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One rising edge: the model follows the requirements, then back to the falling edge.
   task automatic step();
      logic [63:0] clr;
      @(posedge clk);
      clr = '0;
      if (req && we) begin
         case (waddr)
            A_CLR0: clr[31:0]  = wdata & lm(be);
            A_CLR1: clr[63:32] = wdata & lm(be);
            A_EN0:  m_en[31:0]  = (m_en[31:0] & ~lm(be)) | (wdata & lm(be));
            A_EN1:  m_en[63:32] = (m_en[63:32] & ~lm(be)) | (wdata & lm(be));
            A_RT:   if (be[0]) m_rt = wdata[7:0];
            default: ;
         endcase
      end
      m_fl = (m_fl & ~clr) | src;
      @(negedge clk);
   endtask

   task automatic wr(input logic [9:0] a, input logic [3:0] b, input logic [31:0] d);
      req = 1'b1; we = 1'b1; waddr = a; be = b; wdata = d;
      step();
      req = 1'b0; we = 1'b0;
      check("R8 irq after write", 64'(irq), 64'(exp_irq()));
   endtask

   task automatic rd(input string tag, input logic [9:0] a);
      logic [31:0] e;
      req = 1'b1; we = 1'b0; waddr = a; be = 4'h0;
      e = exp_rd(a);
      step();
      req = 1'b0;
      check(tag, 64'(rdata), 64'(e));
      check("R8 irq after read", 64'(irq), 64'(exp_irq()));
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd20141223));
      repeat (3) @(negedge clk);
      check("R1 irq in reset", 64'(irq), 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 irq after reset", 64'(irq), 64'h0);
      rd("R1 enable lo zero", A_EN0);
      rd("R1 enable hi zero", A_EN1);
      rd("R1 status lo zero", A_ST0);
      rd("R1 route zero", A_RT);

      // R3 word and single-lane writes
      wr(A_EN0, 4'hF, 32'hDEAD_BEEF);
      rd("R3 enable lo word", A_EN0);
      check("R3 enable lo value", 64'(rdata), 64'hDEAD_BEEF);
      wr(A_EN1, 4'hF, 32'h0000_0000);
      wr(A_EN1, 4'b0100, 32'hFFFF_FFFF);
      rd("R3 enable hi lane2", A_EN1);
      check("R3 lane2 only", 64'(rdata), 64'h00FF_0000);
      wr(A_EN0, 4'hF, 32'h0000_0020);

      // R2 / R4 / R8 latch, mask and route
      wr(A_RT, 4'h1, 32'h0000_0001);
      rd("R8 route readback", A_RT);
      src = 64'h20; step(); src = '0;
      check("R2 irq after pulse", 64'(irq), 64'h1);
      idle(3);
      check("R2 flag sticky", 64'(irq), 64'h1);
      rd("R4 status lo", A_ST0);
      check("R4 status bit5", 64'(rdata), 64'h20);
      src = 64'h1 << 40; step(); src = '0;
      rd("R4 disabled source masked", A_ST1);
      check("R4 masked value", 64'(rdata), 64'h0);
      wr(A_EN1, 4'h2, 32'h0000_0100);
      rd("R2 pending shows after enable", A_ST1);
      check("R2 pending value", 64'(rdata), 64'h100);

      // R5 clear
      wr(A_CLR0, 4'hF, 32'h0);
      rd("R5 zero bits no effect", A_ST0);
      check("R5 still set", 64'(rdata), 64'h20);
      wr(A_CLR0, 4'hE, 32'h0000_0020);
      rd("R5 disabled lane no effect", A_ST0);
      check("R5 lane ignored", 64'(rdata), 64'h20);
      wr(A_CLR0, 4'h1, 32'h0000_0020);
      wr(A_CLR1, 4'h2, 32'h0000_0100);
      check("R5 irq low after clears", 64'(irq), 64'h0);
      rd("R5 status lo cleared", A_ST0);

      // R6 level source held high through a clear
      src = 64'h20; step();
      wr(A_CLR0, 4'h1, 32'h0000_0020);
      check("R6 set wins", 64'(irq), 64'h1);
      src = '0;
      wr(A_CLR0, 4'h1, 32'h0000_0020);
      check("R6 clears once source low", 64'(irq), 64'h0);

      // R7 / R9
      rd("R7 clear word lo reads 0", A_CLR0);
      rd("R7 clear word hi reads 0", A_CLR1);
      wr(A_NONE, 4'hF, 32'hFFFF_FFFF);
      rd("R9 unmapped reads 0", A_NONE);
      rd("R9 enables untouched", A_EN0);

      // R8 fast class silences output
      src = 64'h20; step(); src = '0;
      wr(A_RT, 4'h1, 32'h0000_0003);
      check("R8 fast class low", 64'(irq), 64'h0);
      wr(A_RT, 4'h1, 32'h0000_0000);
      check("R8 channel 0 low", 64'(irq), 64'h0);
      wr(A_RT, 4'h1, 32'h0000_0001);
      check("R8 regular high", 64'(irq), 64'h1);

      // random phase
      for (int it = 0; it < 1500; it++) begin
         logic [9:0] a;
         int pick;
         src = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom}
               & {$urandom, $urandom};
         pick = $urandom_range(0, 8);
         case (pick)
            0: a = A_CLR0; 1: a = A_CLR1; 2: a = A_EN0; 3: a = A_EN1;
            4: a = A_ST0;  5: a = A_ST1;  6: a = A_RT;  default: a = A_NONE;
         endcase
         if ($urandom_range(0, 1) == 0) begin
            wr(a, 4'($urandom), (a == A_RT) ? 32'($urandom_range(0, 3)) : $urandom);
         end else begin
            rd("R9 random read", a);
         end
      end
      src = '0;
      rd("R4 final status lo", A_ST0);
      rd("R4 final status hi", A_ST1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule